// File: doc/BRIEF.md
# GPIO Edge Event Generator

This block watches a bank of already-synchronized pin levels and emits a one-clock pulse per pin whenever that pin shows an edge of a kind software has selected. Each pulse is meant to feed both a CPU interrupt input and a DMA synchronization input. Edges are seen no matter which way the pin is driven, so software can provoke an event simply by toggling one of its own outputs.

Two per-pin masks decide which edges count: one for rising and one for falling. Software never writes a mask as a whole. It sets or clears individual bits through dedicated set and clear ports, and reading any of those ports returns the mask it controls. A single global enable bit gates every pin's pulse. Register access uses a simple single-cycle bus: a write takes effect at the clock edge, and read data is presented in the same cycle as the address.

Top module: `pin_edge_event_gen`

## Requirements
- R1: After reset both masks are all zero, the enable bit is 0, every pulse output is 0, and every mapped register reads 0.
- R2: The enable register at byte offset 0x08 holds bit 0, which can be read and written. Bits 31..1 always read 0.
- R3: Writing to the set-rise port at 0x24 sets each rising-mask bit that has a 1 in the write data. Bits written as 0 keep their value.
- R4: Writing to the clear-rise port at 0x28 clears each rising-mask bit that has a 1 in the write data. Bits written as 0 keep their value.
- R5: The set-fall port at 0x2C and the clear-fall port at 0x30 change the falling mask in the same way as R3 and R4. A write to one mask's port leaves the other mask unchanged.
- R6: A read of 0x24 or 0x28 returns the rising mask in bits 15..0. A read of 0x2C or 0x30 returns the falling mask. The upper bits read 0.
- R7: A pin whose rising bit is 1 and falling bit is 0 pulses only on a 0-to-1 change of its level.
- R8: A pin whose rising bit is 0 and falling bit is 1 pulses only on a 1-to-0 change of its level.
- R9: A pin with both bits set pulses on every change of its level. A pin with both bits clear never pulses.
- R10: While the enable bit is 0, no pulse output is ever asserted, whatever the masks and the pin activity.
- R11: A level change is seen at the first clock edge that samples the new level. The pulse is high for exactly the following cycle, and it repeats only if the level changes again.
- R12: Reads of unmapped addresses return 0. Writes to them change neither mask nor the enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busSel | input | 1 | Bus access valid this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the same cycle |
| pinLevel | input | 16 | Synchronized pin levels |
| eventPulse | output | 16 | Per-pin interrupt/DMA event pulse |

## Verification
A wrong mask bit stays hidden at the event outputs until its pin changes level. It does show on the very next read of either port for that mask, so the bench reads these ports often between random writes. A stale previous-level register produces a missing pulse, or a pulse at the wrong time, one cycle after the level change. A stuck enable bit shows as a pulse, or as silence, on the first selected edge, so each pulse is compared cycle by cycle against a model.

// File: rtl/pee_pkg.sv
package pee_pkg;
  localparam int unsigned OFS_ENABLE   = 'h08;
  localparam int unsigned OFS_SET_RISE = 'h24;
  localparam int unsigned OFS_CLR_RISE = 'h28;
  localparam int unsigned OFS_SET_FALL = 'h2C;
  localparam int unsigned OFS_CLR_FALL = 'h30;

  typedef struct packed {
    logic setRise;
    logic clrRise;
    logic setFall;
    logic clrFall;
    logic wrEnable;
  } maskStrobe_t;
endpackage

// File: rtl/pee_control.sv
module pee_control
  import pee_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int PIN_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [PIN_W-1:0]  riseMask,
  input  logic [PIN_W-1:0]  fallMask,
  output maskStrobe_t       strb,
  output logic              enBit
);
  logic hitEnable, hitSetRise, hitClrRise, hitSetFall, hitClrFall;
  logic wrCycle, rdCycle;

  assign hitEnable  = busAddr == ADDR_W'(OFS_ENABLE);
  assign hitSetRise = busAddr == ADDR_W'(OFS_SET_RISE);
  assign hitClrRise = busAddr == ADDR_W'(OFS_CLR_RISE);
  assign hitSetFall = busAddr == ADDR_W'(OFS_SET_FALL);
  assign hitClrFall = busAddr == ADDR_W'(OFS_CLR_FALL);

  assign wrCycle = busSel & busWrite;
  assign rdCycle = busSel & ~busWrite;

  always_comb begin
    strb.setRise  = wrCycle & hitSetRise;
    strb.clrRise  = wrCycle & hitClrRise;
    strb.setFall  = wrCycle & hitSetFall;
    strb.clrFall  = wrCycle & hitClrFall;
    strb.wrEnable = wrCycle & hitEnable;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              enBit <= 1'b0;
    else if (strb.wrEnable) enBit <= busWdata[0];
  end

  always_comb begin
    busRdata = '0;
    if (rdCycle) begin
      if (hitEnable)                    busRdata = DATA_W'(enBit);
      else if (hitSetRise | hitClrRise) busRdata = DATA_W'(riseMask);
      else if (hitSetFall | hitClrFall) busRdata = DATA_W'(fallMask);
    end
  end

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb)); // R5
  AST_EN_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEnable |=> enBit == $past(busWdata[0])); // R2
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrEnable |=> $stable(enBit)); // R12
endmodule

// File: rtl/pee_datapath.sv
module pee_datapath
  import pee_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PIN_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  maskStrobe_t       strb,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              enBit,
  input  logic [PIN_W-1:0]  pinLevel,
  output logic [PIN_W-1:0]  riseMask,
  output logic [PIN_W-1:0]  fallMask,
  output logic [PIN_W-1:0]  eventPulse
);
  logic [PIN_W-1:0] wrBits;
  logic [PIN_W-1:0] prevLevel;
  logic [PIN_W-1:0] hitNow;

  assign wrBits = busWdata[PIN_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      riseMask <= '0;
      fallMask <= '0;
    end else begin
      if (strb.setRise)      riseMask <= riseMask | wrBits;
      else if (strb.clrRise) riseMask <= riseMask & ~wrBits;
      if (strb.setFall)      fallMask <= fallMask | wrBits;
      else if (strb.clrFall) fallMask <= fallMask & ~wrBits;
    end
  end

  for (genvar p = 0; p < PIN_W; p++) begin : g_pin
    logic wentUp, wentDown;
    assign wentUp   = pinLevel[p] & ~prevLevel[p];
    assign wentDown = ~pinLevel[p] & prevLevel[p];
    always_comb begin
      unique case ({riseMask[p], fallMask[p]})
        2'b10:   hitNow[p] = wentUp;
        2'b01:   hitNow[p] = wentDown;
        2'b11:   hitNow[p] = wentUp | wentDown;
        default: hitNow[p] = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevLevel  <= '0;
      eventPulse <= '0;
    end else begin
      prevLevel  <= pinLevel;
      eventPulse <= enBit ? hitNow : '0;
    end
  end

  AST_SET_RISE: assert property (@(posedge clk) disable iff (!rstN)
    strb.setRise |=> (riseMask & $past(wrBits)) == $past(wrBits)); // R3
  AST_CLR_RISE: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrRise |=> (riseMask & $past(wrBits)) == '0); // R4
  AST_SET_FALL: assert property (@(posedge clk) disable iff (!rstN)
    strb.setFall |=> (fallMask & $past(wrBits)) == $past(wrBits)); // R5
  AST_CLR_FALL: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrFall |=> (fallMask & $past(wrBits)) == '0); // R5
  AST_RISE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.setRise | strb.clrRise) |=> $stable(riseMask)); // R5
  AST_FALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.setFall | strb.clrFall) |=> $stable(fallMask)); // R5
  AST_GATED_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !enBit |=> eventPulse == '0); // R10
  AST_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    |eventPulse |-> ($past(pinLevel) ^ $past(prevLevel)) != '0); // R11
endmodule

// File: rtl/pin_edge_event_gen.sv
module pin_edge_event_gen
  import pee_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int PIN_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [PIN_W-1:0]  pinLevel,
  output logic [PIN_W-1:0]  eventPulse
);
  maskStrobe_t      strb;
  logic             enBit;
  logic [PIN_W-1:0] riseMask, fallMask;

  pee_control #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PIN_W(PIN_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .riseMask(riseMask), .fallMask(fallMask), .strb(strb), .enBit(enBit)
  );

  pee_datapath #(.DATA_W(DATA_W), .PIN_W(PIN_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busWdata(busWdata), .enBit(enBit),
    .pinLevel(pinLevel), .riseMask(riseMask), .fallMask(fallMask),
    .eventPulse(eventPulse)
  );
endmodule

// File: tb/sim_pin_edge_event_gen.sv
module sim_pin_edge_event_gen;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWrite = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [15:0] pinLevel = '0;
  logic [15:0] eventPulse;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [15:0] mRise = '0, mFall = '0, mPrev = '0;
  logic        mEn = 1'b0;

  always #10 clk = ~clk;

  pin_edge_event_gen u0 (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .pinLevel(pinLevel), .eventPulse(eventPulse)
  );

  function automatic logic [15:0] expPulse(logic en, logic [15:0] rm, logic [15:0] fm,
                                           logic [15:0] now, logic [15:0] prev);
    return en ? ((now & ~prev & rm) | (~now & prev & fm)) : 16'h0;
  endfunction

  function automatic logic [31:0] expRead(logic [7:0] a);
    case (a)
      8'h08:         return {31'h0, mEn};
      8'h24, 8'h28:  return {16'h0, mRise};
      8'h2C, 8'h30:  return {16'h0, mFall};
      default:       return 32'h0;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One bus cycle plus one pin pattern; read data and pulse are checked away from edges.
  task automatic step(bit sel, bit wr, logic [7:0] a, logic [31:0] d, logic [15:0] pins,
                      string req);
    logic [15:0] ep;
    @(negedge clk);
    busSel = sel; busWrite = wr; busAddr = a; busWdata = d; pinLevel = pins;
    #1;
    if (sel && !wr) check({req, " read"}, busRdata, expRead(a));
    ep = expPulse(mEn, mRise, mFall, pins, mPrev);
    @(posedge clk);
    if (sel && wr) begin
      case (a)
        8'h08: mEn = d[0];
        8'h24: mRise = mRise | d[15:0];
        8'h28: mRise = mRise & ~d[15:0];
        8'h2C: mFall = mFall | d[15:0];
        8'h30: mFall = mFall & ~d[15:0];
        default: ;
      endcase
    end
    mPrev = pins;
    #5;
    check({req, " pulse"}, {16'h0, eventPulse}, {16'h0, ep});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] addrs [8] = '{8'h08, 8'h24, 8'h28, 8'h2C, 8'h30, 8'h00, 8'h20, 8'h34};
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk);
    #3;
    check("R1 pulse at reset", {16'h0, eventPulse}, 32'h0);
    @(negedge clk) rstN = 1'b1;

    // R1: reset contents of every register
    step(1, 0, 8'h08, 0, 16'h0, "R1");
    step(1, 0, 8'h24, 0, 16'h0, "R1");
    step(1, 0, 8'h2C, 0, 16'h0, "R1");
    // R2: enable bit and zero upper bits
    step(1, 1, 8'h08, 32'hFFFF_FFFF, 16'h0, "R2");
    step(1, 0, 8'h08, 0, 16'h0, "R2");
    // R3/R4: set then clear rising bits, zeros leave others
    step(1, 1, 8'h24, 32'h0000_00F1, 16'h0, "R3");
    step(1, 1, 8'h24, 32'h0000_0000, 16'h0, "R3");
    step(1, 0, 8'h28, 0, 16'h0, "R6");
    step(1, 1, 8'h28, 32'h0000_0011, 16'h0, "R4");
    step(1, 0, 8'h24, 0, 16'h0, "R4");
    // R5: falling mask, and rising untouched
    step(1, 1, 8'h2C, 32'hFFFF_0F00, 16'h0, "R5");
    step(1, 1, 8'h30, 32'h0000_0300, 16'h0, "R5");
    step(1, 0, 8'h30, 0, 16'h0, "R6");
    step(1, 0, 8'h24, 0, 16'h0, "R5");
    // masks now: rise=00E0, fall=0C00. Add a both-edge pin 15.
    step(1, 1, 8'h24, 32'h8000, 16'h0, "R9");
    step(1, 1, 8'h2C, 32'h8000, 16'h0, "R9");
    // R7: rising on pin 5, R9 on pin 15, pin 0 (mode 00) silent
    step(0, 0, 0, 0, 16'h8021, "R7");
    step(0, 0, 0, 0, 16'h8021, "R11");
    // R8: falling on pin 10 (mode 01) after it goes high then low
    step(0, 0, 0, 0, 16'h8421, "R8");
    step(0, 0, 0, 0, 16'h0000, "R8");
    step(0, 0, 0, 0, 16'h0000, "R11");
    // R10: disable and toggle everything
    step(1, 1, 8'h08, 32'h0, 16'hFFFF, "R10");
    step(0, 0, 0, 0, 16'h0000, "R10");
    step(0, 0, 0, 0, 16'hFFFF, "R10");
    // R12: unmapped write and read
    step(1, 1, 8'h20, 32'hFFFF_FFFF, 16'hFFFF, "R12");
    step(1, 1, 8'h0C, 32'hFFFF_FFFF, 16'hFFFF, "R12");
    step(1, 0, 8'h20, 0, 16'hFFFF, "R12");
    step(1, 0, 8'h24, 0, 16'hFFFF, "R12");
    step(1, 0, 8'h08, 0, 16'hFFFF, "R12");
    step(1, 1, 8'h08, 32'h1, 16'hFFFF, "R2");

    for (int i = 0; i < 4000; i++) begin
      logic [7:0] a;
      a = addrs[$urandom_range(0, 7)];
      step($urandom_range(0, 1), ($urandom_range(0, 3) == 0), a, $urandom,
           16'($urandom), "R7/R8/R9/R10/R11 random");
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule